// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the eight status flags of an I2C controller and shows them to the CPU as one read-only byte. The bus engine sends it single-cycle event strobes: a start generated by this controller, a stop seen on the bus, lost arbitration and a request to leave the current transfer. From these the block tracks two flags: the controller is acting as bus master, and it has lost arbitration. The other six flags (extension code, address hit, transmit mode, acknowledge seen, start seen, stop seen) each take a plain set input and clear input from the engine.

A CPU read is signalled by a one-cycle read strobe. The byte on the read port is always the registered flag state, so a read returns the flags as they stood before the read. Any read, whatever bit software wants, then clears the arbitration-lost flag. Software must therefore take that flag from the first read after the event. Turning the controller's enable off clears every flag.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: The byte is packed, bit 7 down to bit 0, as: master, arbitration lost, extension code, address hit, transmit mode, acknowledge seen, start seen, stop seen.
- R3: A start-generated strobe sets the master flag at the next clock edge, unless a clear event for it occurs in the same cycle.
- R4: A stop-detected, arbitration-lost or exit-request strobe clears the master flag at the next clock edge. A clear wins over a start-generated strobe in the same cycle.
- R5: When enable goes from 1 to 0, all eight flags are 0 one clock edge later. This clear wins over any set in that cycle.
- R6: An arbitration-lost strobe sets the arbitration-lost flag at the next clock edge.
- R7: The read port shows the flags as they were before the read. After the clock edge that ends a read-strobe cycle, the arbitration-lost flag is 0.
- R8: If a read strobe and an arbitration-lost strobe come in the same cycle, the arbitration-lost flag is 1 after that edge.
- R9: Each of the six other flags is set by its set input and cleared by its clear input. Bit i of the set and clear vectors maps to bit i of the byte (i = 0..5). Clear wins when both are asserted.
- R10: A read strobe has no effect on the master flag or on the six other flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enable; a 1-to-0 change clears all flags |
| start_gen_i | input | 1 | Strobe: this controller generated a start |
| stop_det_i | input | 1 | Strobe: stop condition detected |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| exit_req_i | input | 1 | Strobe: request to leave communication |
| rd_strobe_i | input | 1 | Strobe: CPU reads the status byte |
| aux_set_i | input | 6 | Set inputs of flags 5..0 |
| aux_clr_i | input | 6 | Clear inputs of flags 5..0 |
| rd_data_o | output | 8 | Packed status byte |

## Verification
Each flag passes through exactly one register, so every strobe's effect shows after the next rising edge. A fall in enable is seen through the registered copy of enable, and the clear it causes also lands on the first edge after the fall. The bench drives inputs on the falling edge, waits through one rising edge, and samples at the following falling edge. For R7 it also samples the read port before that edge, while the strobe is still high, to confirm that a read returns the pre-clear value.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int unsigned AUX_W  = 6;
    localparam int unsigned STAT_W = AUX_W + 2;

    typedef struct packed {
        logic             master;
        logic             arb_lost;
        logic [AUX_W-1:0] aux;
    } stat_t;
endpackage

// File: rtl/i2c_stat_en_edge.sv
module i2c_stat_en_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    output logic flush_o
);
    typedef struct packed {
        logic en_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = enable_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flush_o = st_q.en_prev & ~enable_i;

    // R5
    flush_follows_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> ($past(enable_i) && !enable_i));
endmodule

// File: rtl/i2c_stat_flag_bit.sv
module i2c_stat_flag_bit (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic flush_i,
    output logic q_o
);
    typedef struct packed {
        logic val;
    } bit_st_t;

    bit_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || flush_i) st_d.val = 1'b0;
        else if (set_i)       st_d.val = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q.val;

    // R9
    aux_clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i || flush_i) |=> !q_o);
    // R9
    aux_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !clr_i && !flush_i) |=> q_o);
endmodule

// File: rtl/i2c_stat_arb.sv
module i2c_stat_arb (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_gen_i,
    input  logic stop_det_i,
    input  logic arb_lost_i,
    input  logic exit_req_i,
    input  logic rd_strobe_i,
    input  logic flush_i,
    output logic master_o,
    output logic arb_o
);
    typedef struct packed {
        logic master;
        logic arb;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    mst_clr;

    always_comb begin
        st_d    = st_q;
        mst_clr = stop_det_i | arb_lost_i | exit_req_i | flush_i;
        if (mst_clr)          st_d.master = 1'b0;
        else if (start_gen_i) st_d.master = 1'b1;

        if (flush_i)          st_d.arb = 1'b0;
        else if (arb_lost_i)  st_d.arb = 1'b1;
        else if (rd_strobe_i) st_d.arb = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign master_o = st_q.master;
    assign arb_o    = st_q.arb;

    // R3
    master_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_gen_i && !stop_det_i && !arb_lost_i && !exit_req_i && !flush_i) |=> master_o);
    // R4
    master_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_det_i || arb_lost_i || exit_req_i) |=> !master_o);
    // R7
    arb_read_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_strobe_i && !arb_lost_i) |=> !arb_o);
    // R8
    arb_keep_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arb_lost_i && !flush_i) |=> arb_o);
    // R10
    read_keeps_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_strobe_i && !start_gen_i && !mst_clr) |=> $stable(master_o));
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              start_gen_i,
    input  logic              stop_det_i,
    input  logic              arb_lost_i,
    input  logic              exit_req_i,
    input  logic              rd_strobe_i,
    input  logic [AUX_W-1:0]  aux_set_i,
    input  logic [AUX_W-1:0]  aux_clr_i,
    output logic [STAT_W-1:0] rd_data_o
);
    logic  flush;
    stat_t stat;

    i2c_stat_en_edge u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .flush_o  (flush)
    );

    i2c_stat_arb u_arb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_gen_i (start_gen_i),
        .stop_det_i  (stop_det_i),
        .arb_lost_i  (arb_lost_i),
        .exit_req_i  (exit_req_i),
        .rd_strobe_i (rd_strobe_i),
        .flush_i     (flush),
        .master_o    (stat.master),
        .arb_o       (stat.arb_lost)
    );

    for (genvar gi = 0; gi < AUX_W; gi++) begin : g_aux
        i2c_stat_flag_bit u_flag (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .set_i   (aux_set_i[gi]),
            .clr_i   (aux_clr_i[gi]),
            .flush_i (flush),
            .q_o     (stat.aux[gi])
        );
    end

    // R2: packed order master, arbitration lost, aux[5:0]
    assign rd_data_o = stat;

    // R5
    flush_clears_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush |=> (rd_data_o == '0));
    // R10
    read_keeps_aux_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_strobe_i && aux_set_i == '0 && aux_clr_i == '0 && !flush) |=> $stable(rd_data_o[AUX_W-1:0]));
endmodule

// File: tb/i2c_stat_reg_tb.sv
module i2c_stat_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, sg = 1'b0, sd = 1'b0, al = 1'b0, ex = 1'b0, rd = 1'b0;
    logic [5:0] aset = '0, aclr = '0;
    logic [7:0] dout;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    i2c_stat_reg u_dut (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .start_gen_i(sg),
        .stop_det_i(sd), .arb_lost_i(al), .exit_req_i(ex), .rd_strobe_i(rd),
        .aux_set_i(aset), .aux_clr_i(aclr), .rd_data_o(dout)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
        sg = 0; sd = 0; al = 0; ex = 0; rd = 0; aset = '0; aclr = '0;
    endtask

    task automatic t_reset();
        chk("R1", dout, 8'h00);
    endtask

    task automatic t_master();
        en = 1; sg = 1; tick();
        chk("R3", dout, 8'h80);
        sd = 1; tick();
        chk("R4 stop", dout, 8'h00);
        sg = 1; tick(); ex = 1; tick();
        chk("R4 exit", dout, 8'h00);
        sg = 1; tick(); al = 1; tick();
        chk("R4/R6 arb", dout, 8'h40);
        rd = 1; tick();
        sg = 1; sd = 1; tick();
        chk("R4 clear wins", dout, 8'h00);
    endtask

    task automatic t_arb_read();
        sg = 1; tick(); al = 1; tick();
        chk("R6", dout, 8'h40);
        sg = 1; aset = 6'h01; tick();
        rd = 1;
        chk("R7 pre-clear", dout, 8'hC1);
        tick();
        chk("R7/R10 after read", dout, 8'h81);
        rd = 1; al = 1; tick();
        chk("R8", dout, 8'h41);
        rd = 1; tick();
        chk("R7 second read", dout, 8'h01);
        aclr = 6'h01; tick();
    endtask

    task automatic t_aux();
        aset = 6'h2A; tick();
        chk("R9 set", dout, 8'h2A);
        aset = 6'h15; aclr = 6'h08; tick();
        chk("R9 mix", dout, 8'h37);
        aset = 6'h01; aclr = 6'h01; tick();
        chk("R9 clear wins", dout, 8'h36);
        rd = 1; tick();
        chk("R10", dout, 8'h36);
        aclr = 6'h3F; tick();
        chk("R2 aux clear", dout, 8'h00);
    endtask

    task automatic t_disable();
        sg = 1; aset = 6'h3F; tick(); al = 1; tick();
        sg = 1; tick();
        chk("R2 all", dout, 8'hFF);
        en = 0;
        chk("R5 before edge", dout, 8'hFF);
        sg = 1; aset = 6'h3F; al = 1; tick();
        chk("R5", dout, 8'h00);
        aset = 6'h04; tick();
        chk("R5 steady low no clear", dout, 8'h04);
        en = 1; tick(); en = 0; tick();
        chk("R5 again", dout, 8'h00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_master();
        t_arb_read();
        t_aux();
        t_disable();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            summary();
        end
    end
endmodule